// File: doc/BRIEF.md
# Descriptor-Table Scatter/Gather DMA Engine

The engine moves one device-side byte buffer to or from system memory by following a table of region descriptors held in memory. On a start pulse it captures the table base, the buffer byte count and the transfer direction. It then reads descriptors one at a time and turns each region into address/length commands for a memory master. For every accepted command it gates a 32-bit beat stream between a source and a sink. The surrounding logic decides whether memory or the device sits on each side of that stream. The direction is carried out on the command as a write flag.

Each descriptor is two little-endian 32-bit words. The first word is the region's physical address. The second word carries an even byte count in its low half, where zero stands for 64 KiB, and an end-of-table flag in its top bit. The walk ends for one of three reasons: the buffer is used up, a region flagged as final is exhausted, or the table pointer has moved one 4 KiB page past the base. Completion is a one-cycle pulse. It comes with a level that tells whether the table ran out before the buffer did.

Top module: `prd_dma_engine`

## Requirements
- R1: After a start, descriptor n (counting from 0) is read as two word reads, at base+8n and then at base+8n+4. The pointer moves on by 8 bytes after each descriptor.
- R2: A region's length is bits 15:1 of the second word with bit 0 taken as zero, so an odd count field such as 0x0067 gives 102 bytes.
- R3: A count field whose bits 15:1 are all zero gives a region of 65536 bytes.
- R4: Once a region whose second word has bit 31 set is exhausted, no further descriptor is read. If buffer bytes remain at that point, completion reports underrun_o = 1.
- R5: No descriptor read is issued once the pointer is 4096 or more bytes past the base. A table without a final flag therefore yields at most 512 descriptors, followed by underrun.
- R6: Each command carries the current region address. Its length is the smaller of the bytes left in the buffer and the bytes left in the region. Its write flag equals dir_i as captured at start. Address and length hold steady while the command waits for ready.
- R7: After each chunk, the region address and buf_idx_o both advance by the chunk length. At completion, buf_idx_o equals the total number of bytes commanded.
- R8: After each command is accepted, exactly ceil(length/4) beats pass from source to sink, with data unchanged and in order. No beat passes at any other time.
- R9: Completion is a one-cycle done_o pulse while busy_o is low. underrun_o = 0 when the whole buffer was consumed. A zero-byte buffer completes with no descriptor read.
- R10: A start pulse while busy_o is high is ignored. A start while idle reloads the pointer from the base and clears the region state and buf_idx_o.
- R11: Out of reset the engine is idle: busy_o, done_o, cmd_valid_o, dsc_rd_o, snk_valid_o and src_ready_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| dir_i | input | 1 | 1 = device to memory (memory write), 0 = memory to device |
| table_base_i | input | 32 | Byte address of the descriptor table |
| buf_bytes_i | input | BUF_W | Device buffer length in bytes |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| underrun_o | output | 1 | Table ended before the buffer was consumed; valid from done_o until the next start |
| buf_idx_o | output | BUF_W | Bytes of the buffer consumed so far |
| dsc_rd_o | output | 1 | Descriptor word read request, held until answered |
| dsc_addr_o | output | 32 | Descriptor word address |
| dsc_rvalid_i | input | 1 | Read data valid; completes the request |
| dsc_rdata_i | input | 32 | Descriptor word |
| cmd_valid_o | output | 1 | Chunk command valid |
| cmd_ready_i | input | 1 | Chunk command accepted |
| cmd_write_o | output | 1 | Chunk is a memory write |
| cmd_addr_o | output | 32 | Chunk memory address |
| cmd_len_o | output | 17 | Chunk length in bytes, 1 to 65536 |
| src_valid_i | input | 1 | Source beat valid |
| src_data_i | input | DATA_W | Source beat data |
| src_ready_o | output | 1 | Source beat taken |
| snk_valid_o | output | 1 | Sink beat valid |
| snk_data_o | output | DATA_W | Sink beat data |
| snk_ready_i | input | 1 | Sink beat accepted |

## Verification
Suppose the pointer, the region length or the last flag is held wrongly. The first symptom is then a descriptor read at the wrong address, or a missing or extra read. It shows on the fetch port within a few cycles of the region running out. A wrong chunk length or region address shows on the very command that carries it. A slip in the beat counter shows as a beat count or data order mismatch before the next command. A bad buffer index or bad termination logic shows in the done/underrun result and in the final buf_idx_o.

// File: rtl/prd_dma_pkg.sv
`timescale 1ns/1ps
package prd_dma_pkg;
  localparam int unsigned REGION_W = 17;   // holds 1..65536
  localparam int unsigned WORD_W   = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_FETCH, ST_CMD, ST_DATA
  } eng_state_e;

  typedef struct packed {
    logic [WORD_W-1:0]   addr;
    logic [REGION_W-1:0] len;
    logic                last;
  } region_t;

  // cnt_hi is bits 15:1 of the count word; bit 0 is dropped
  function automatic region_t decode_desc(input logic [WORD_W-1:0] w0,
                                          input logic last_bit,
                                          input logic [14:0] cnt_hi);
    region_t r;
    r.addr = w0;
    r.last = last_bit;
    if (cnt_hi == 15'd0) r.len = REGION_W'(17'h10000);
    else                 r.len = {1'b0, cnt_hi, 1'b0};
    return r;
  endfunction
endpackage

// File: rtl/prd_desc_fetch.sv
`timescale 1ns/1ps
module prd_desc_fetch
  import prd_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [WORD_W-1:0] ptr_i,
  output logic              dsc_rd_o,
  output logic [WORD_W-1:0] dsc_addr_o,
  input  logic              dsc_rvalid_i,
  input  logic [WORD_W-1:0] dsc_rdata_i,
  output logic              done_o,
  output region_t           region_o
);
  typedef enum logic [1:0] {F_IDLE, F_W0, F_W1} fetch_state_e;

  fetch_state_e      st_q;
  logic [WORD_W-1:0] ptr_q;
  logic [WORD_W-1:0] w0_q;
  region_t           reg_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      ptr_q  <= '0;
      w0_q   <= '0;
      reg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        F_IDLE: if (go_i) begin
          ptr_q <= ptr_i;
          st_q  <= F_W0;
        end
        F_W0: if (dsc_rvalid_i) begin
          w0_q <= dsc_rdata_i;
          st_q <= F_W1;
        end
        F_W1: if (dsc_rvalid_i) begin
          reg_q  <= decode_desc(w0_q, dsc_rdata_i[31], dsc_rdata_i[15:1]);
          done_q <= 1'b1;
          st_q   <= F_IDLE;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign dsc_rd_o   = (st_q != F_IDLE);
  assign dsc_addr_o = (st_q == F_W1) ? ptr_q + WORD_W'(4) : ptr_q;
  assign done_o     = done_q;
  assign region_o   = reg_q;

  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_rd_o && !dsc_rvalid_i |=> dsc_rd_o && $stable(dsc_addr_o));

  assert_len_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (region_o.len != '0) && (region_o.len <= REGION_W'(17'h10000)) && !region_o.len[0]);
endmodule

// File: rtl/prd_beat_gate.sv
`timescale 1ns/1ps
module prd_beat_gate
  import prd_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [REGION_W-1:0] bytes_i,
  output logic                done_o,
  input  logic                src_valid_i,
  input  logic [DATA_W-1:0]   src_data_i,
  output logic                src_ready_o,
  output logic                snk_valid_o,
  output logic [DATA_W-1:0]   snk_data_o,
  input  logic                snk_ready_i
);
  localparam int unsigned BEAT_BYTES = DATA_W / 8;
  localparam int unsigned SH         = $clog2(BEAT_BYTES);
  localparam int unsigned BEAT_W     = REGION_W - SH + 1;

  logic [BEAT_W-1:0]   left_q;
  logic [REGION_W:0]   round_up;
  logic                active;
  logic                xfer;
  logic                done_q;

  assign round_up    = {1'b0, bytes_i} + (REGION_W+1)'(BEAT_BYTES - 1);
  assign active      = (left_q != '0);
  assign snk_valid_o = src_valid_i & active;
  assign src_ready_o = snk_ready_i & active;
  assign snk_data_o  = src_data_i;
  assign xfer        = snk_valid_o & snk_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= xfer && (left_q == BEAT_W'(1));
      if (load_i)    left_q <= BEAT_W'(round_up >> SH);
      else if (xfer) left_q <= left_q - BEAT_W'(1);
    end
  end

  assign done_o = done_q;

  assert_load_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !active && (bytes_i != '0));
endmodule

// File: rtl/prd_dma_engine.sv
`timescale 1ns/1ps
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int unsigned BUF_W       = 20,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TABLE_LIMIT = 4096
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                dir_i,
  input  logic [WORD_W-1:0]   table_base_i,
  input  logic [BUF_W-1:0]    buf_bytes_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                underrun_o,
  output logic [BUF_W-1:0]    buf_idx_o,
  output logic                dsc_rd_o,
  output logic [WORD_W-1:0]   dsc_addr_o,
  input  logic                dsc_rvalid_i,
  input  logic [WORD_W-1:0]   dsc_rdata_i,
  output logic                cmd_valid_o,
  input  logic                cmd_ready_i,
  output logic                cmd_write_o,
  output logic [WORD_W-1:0]   cmd_addr_o,
  output logic [REGION_W-1:0] cmd_len_o,
  input  logic                src_valid_i,
  input  logic [DATA_W-1:0]   src_data_i,
  output logic                src_ready_o,
  output logic                snk_valid_o,
  output logic [DATA_W-1:0]   snk_data_o,
  input  logic                snk_ready_i
);
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned CMP_W      = (BUF_W > REGION_W) ? BUF_W : REGION_W;

  eng_state_e          st_q;
  logic [WORD_W-1:0]   base_q, ptr_q;
  logic [BUF_W-1:0]    buf_q, idx_q;
  logic                dir_q;
  logic [WORD_W-1:0]   cur_addr_q;
  logic [REGION_W-1:0] cur_len_q, chunk_q, chunk_d;
  logic                cur_last_q;
  logic                done_q, und_q;

  logic [CMP_W-1:0]    rem_w, len_w;
  logic [WORD_W-1:0]   walked;
  logic                buf_empty, region_empty, table_end;
  logic                fetch_go, fetch_done, gate_load, gate_done;
  region_t             fetched;

  assign rem_w        = CMP_W'(buf_q - idx_q);
  assign len_w        = CMP_W'(cur_len_q);
  assign chunk_d      = REGION_W'((rem_w < len_w) ? rem_w : len_w);
  assign walked       = ptr_q - base_q;
  assign buf_empty    = (idx_q >= buf_q);
  assign region_empty = (cur_len_q == '0);
  assign table_end    = cur_last_q || (walked >= WORD_W'(TABLE_LIMIT));
  assign fetch_go     = (st_q == ST_EVAL) && !buf_empty && region_empty && !table_end;
  assign gate_load    = (st_q == ST_CMD) && cmd_ready_i;

  prd_desc_fetch u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (fetch_go),
    .ptr_i        (ptr_q),
    .dsc_rd_o     (dsc_rd_o),
    .dsc_addr_o   (dsc_addr_o),
    .dsc_rvalid_i (dsc_rvalid_i),
    .dsc_rdata_i  (dsc_rdata_i),
    .done_o       (fetch_done),
    .region_o     (fetched)
  );

  prd_beat_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (gate_load),
    .bytes_i     (chunk_q),
    .done_o      (gate_done),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_ready_o (src_ready_o),
    .snk_valid_o (snk_valid_o),
    .snk_data_o  (snk_data_o),
    .snk_ready_i (snk_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      base_q     <= '0;
      ptr_q      <= '0;
      buf_q      <= '0;
      idx_q      <= '0;
      dir_q      <= 1'b0;
      cur_addr_q <= '0;
      cur_len_q  <= '0;
      cur_last_q <= 1'b0;
      chunk_q    <= '0;
      done_q     <= 1'b0;
      und_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          base_q     <= table_base_i;
          ptr_q      <= table_base_i;
          buf_q      <= buf_bytes_i;
          dir_q      <= dir_i;
          idx_q      <= '0;
          cur_addr_q <= '0;
          cur_len_q  <= '0;
          cur_last_q <= 1'b0;
          und_q      <= 1'b0;
          st_q       <= ST_EVAL;
        end
        ST_EVAL: begin
          if (buf_empty) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (region_empty) begin
            if (table_end) begin
              und_q  <= 1'b1;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_FETCH;
            end
          end else begin
            chunk_q <= chunk_d;
            st_q    <= ST_CMD;
          end
        end
        ST_FETCH: if (fetch_done) begin
          cur_addr_q <= fetched.addr;
          cur_len_q  <= fetched.len;
          cur_last_q <= fetched.last;
          ptr_q      <= ptr_q + WORD_W'(DESC_BYTES);
          st_q       <= ST_EVAL;
        end
        ST_CMD: if (cmd_ready_i) st_q <= ST_DATA;
        ST_DATA: if (gate_done) begin
          cur_addr_q <= cur_addr_q + WORD_W'(chunk_q);
          cur_len_q  <= cur_len_q - chunk_q;
          idx_q      <= idx_q + BUF_W'(chunk_q);
          st_q       <= ST_EVAL;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign underrun_o  = und_q;
  assign buf_idx_o   = idx_q;
  assign cmd_valid_o = (st_q == ST_CMD);
  assign cmd_write_o = dir_q;
  assign cmd_addr_o  = cur_addr_q;
  assign cmd_len_o   = chunk_q;

  assert_no_fetch_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_rd_o |-> !cur_last_q && (cur_len_q == '0));

  assert_page_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_rd_o |-> (dsc_addr_o - base_q) < WORD_W'(TABLE_LIMIT + DESC_BYTES));

  assert_cmd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_len_o));

  assert_chunk_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_len_o != '0) && (cmd_len_o <= cur_len_q) && (CMP_W'(cmd_len_o) <= rem_w));

  assert_idx_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= buf_q);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !dsc_rd_o && !cmd_valid_o);
endmodule

// File: tb/sim_prd_dma_engine.sv
`timescale 1ns/1ps
module sim_prd_dma_engine;
  localparam int BUF_W = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir = 1'b0;
  logic [31:0] table_base = '0;
  logic [BUF_W-1:0] buf_bytes = '0;
  logic        busy, done, underrun;
  logic [BUF_W-1:0] buf_idx;
  logic        dsc_rd, dsc_rvalid = 1'b0;
  logic [31:0] dsc_addr, dsc_rdata = '0;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_write;
  logic [31:0] cmd_addr;
  logic [16:0] cmd_len;
  logic        src_valid = 1'b0, src_ready, snk_valid, snk_ready = 1'b0;
  logic [31:0] src_data = '0, snk_data;

  always #2.5 clk = ~clk;

  prd_dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir),
    .table_base_i(table_base), .buf_bytes_i(buf_bytes),
    .busy_o(busy), .done_o(done), .underrun_o(underrun), .buf_idx_o(buf_idx),
    .dsc_rd_o(dsc_rd), .dsc_addr_o(dsc_addr), .dsc_rvalid_i(dsc_rvalid), .dsc_rdata_i(dsc_rdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_write_o(cmd_write),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .snk_valid_o(snk_valid), .snk_data_o(snk_data), .snk_ready_i(snk_ready)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:2047];
  logic [31:0] mem_base = '0;
  bit rnd_on = 1'b0;

  // observed
  int a_nf, a_nc, a_beats, a_mism, tx_cnt, rx_cnt;
  logic [31:0] a_faddr [0:2047];
  logic [31:0] a_caddr [0:1023];
  int          a_clen  [0:1023];
  bit          a_cwr_bad, seen_done, seen_und;
  // expected
  int e_nf, e_nc, e_beats, e_idx;
  bit e_und;
  logic [31:0] e_faddr [0:1023];
  logic [31:0] e_caddr [0:1023];
  int          e_clen  [0:1023];
  bit          cur_dir;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] off = (a - mem_base) >> 2;
    return mem[off[10:0]];
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = '0;
  endtask

  task automatic put_desc(input int n, input logic [31:0] addr, input logic [31:0] cw);
    mem[2*n]   = addr;
    mem[2*n+1] = cw;
  endtask

  task automatic model(input logic [31:0] base, input int bufn);
    int idx = 0, clen = 0, ch;
    bit clast = 0;
    logic [31:0] ptr = base, caddr = '0, w0, w1;
    e_nf = 0; e_nc = 0; e_beats = 0;
    while (1) begin
      if (idx >= bufn) begin e_und = 0; break; end
      if (clen == 0) begin
        if (clast || (ptr - base) >= 32'd4096) begin e_und = 1; break; end
        w0 = mem_rd(ptr); w1 = mem_rd(ptr + 4);
        e_faddr[e_nf] = ptr; e_nf++; ptr += 8;
        clen = int'({w1[15:1], 1'b0});
        if (clen == 0) clen = 65536;
        caddr = w0; clast = w1[31];
      end else begin
        ch = (bufn - idx < clen) ? bufn - idx : clen;
        e_caddr[e_nc] = caddr; e_clen[e_nc] = ch; e_nc++;
        e_beats += (ch + 3) / 4;
        caddr += 32'(ch); clen -= ch; idx += ch;
      end
    end
    e_idx = idx;
  endtask

  // stimulus at negedge, sampling 2 ns later, just ahead of the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      cmd_ready = !rnd_on || ($urandom % 4 != 0);
      src_valid = !rnd_on || ($urandom % 3 != 0);
      snk_ready = !rnd_on || ($urandom % 3 != 0);
      src_data  = tx_cnt;
      if (dsc_rd && (!rnd_on || ($urandom % 2 == 0))) begin
        dsc_rvalid = 1'b1; dsc_rdata = mem_rd(dsc_addr);
      end else begin
        dsc_rvalid = 1'b0; dsc_rdata = '0;
      end
      #2;
      if (src_valid && src_ready) tx_cnt++;
      if (snk_valid && snk_ready) begin
        if (snk_data != 32'(rx_cnt)) a_mism++;
        rx_cnt++; a_beats++;
      end
      if (dsc_rd && dsc_rvalid && a_nf < 2048) begin a_faddr[a_nf] = dsc_addr; a_nf++; end
      if (cmd_valid && cmd_ready && a_nc < 1024) begin
        a_caddr[a_nc] = cmd_addr; a_clen[a_nc] = int'(cmd_len);
        if (cmd_write != cur_dir) a_cwr_bad = 1'b1;
        a_nc++;
      end
      if (done) begin seen_done = 1'b1; seen_und = underrun; end
    end
  end

  task automatic run_case(input string nm, input string und_req, input logic [31:0] base,
                          input int bufn, input bit d, input bit glitch);
    int cyc = 0, fbad = 0, cbad = 0;
    mem_base = base;
    model(base, bufn);
    a_nf = 0; a_nc = 0; a_beats = 0; a_mism = 0; tx_cnt = 0; rx_cnt = 0;
    a_cwr_bad = 0; seen_done = 0; seen_und = 0; cur_dir = d;
    @(negedge clk);
    table_base = base; buf_bytes = BUF_W'(bufn); dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      if (glitch && cyc == 12) begin
        chk("R10", {nm, " busy at restart attempt"}, busy, 1);
        start = 1'b1; table_base = base + 32'h40; buf_bytes = '0; dir = !d;
      end else start = 1'b0;
    end
    chk("R9", {nm, " done seen"}, seen_done, 1);
    chk(und_req, {nm, " underrun"}, seen_und, e_und);
    chk("R1", {nm, " descriptor reads"}, a_nf, 2 * e_nf);
    for (int k = 0; k < e_nf && 2*k+1 < a_nf; k++)
      if (a_faddr[2*k] != e_faddr[k] || a_faddr[2*k+1] != e_faddr[k] + 4) fbad++;
    chk("R1", {nm, " descriptor read addresses bad"}, fbad, 0);
    chk("R6", {nm, " command count"}, a_nc, e_nc);
    for (int k = 0; k < e_nc && k < a_nc; k++)
      if (a_caddr[k] != e_caddr[k] || a_clen[k] != e_clen[k]) cbad++;
    chk("R6", {nm, " command addr/len bad"}, cbad, 0);
    chk("R6", {nm, " command write flag bad"}, a_cwr_bad, 0);
    chk("R8", {nm, " beats"}, a_beats, e_beats);
    chk("R8", {nm, " data order errors"}, a_mism, 0);
    chk("R7", {nm, " final buffer index"}, buf_idx, e_idx);
    @(negedge clk);
    chk("R9", {nm, " busy after done"}, busy, 0);
  endtask

  initial begin
    #(5 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    a_nf = 0; a_nc = 0; a_beats = 0; a_mism = 0; tx_cnt = 0; rx_cnt = 0;
    repeat (4) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11", "busy in reset", busy, 0);
    chk("R11", "done in reset", done, 0);
    chk("R11", "cmd_valid in reset", cmd_valid, 0);
    chk("R11", "dsc_rd in reset", dsc_rd, 0);
    chk("R11", "snk_valid in reset", snk_valid, 0);
    chk("R11", "src_ready in reset", src_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 R9: single final region exactly matching buffer
    clear_mem(); put_desc(0, 32'h0001_0000, 32'h8000_0064);
    run_case("single", "R9", 32'h0000_2000, 100, 1'b1, 1'b0);

    // R2 R4: odd count field 0x67 -> 102 bytes, final, buffer longer
    clear_mem(); put_desc(0, 32'h0003_0000, 32'h8000_0067);
    run_case("odd count", "R4", 32'h0000_3000, 200, 1'b0, 1'b0);

    // R3: zero count field -> 65536 bytes, then a short final region
    clear_mem(); put_desc(0, 32'h0010_0000, 32'h0000_0000); put_desc(1, 32'h0020_0000, 32'h8000_0064);
    run_case("zero count", "R9", 32'h0000_4000, 65540, 1'b1, 1'b0);

    // R6 R7: buffer ends inside a region
    clear_mem(); put_desc(0, 32'h0004_0002, 32'h8000_03E8);
    run_case("partial region", "R9", 32'h0000_5000, 300, 1'b0, 1'b0);

    // R8: 7-byte buffer needs 2 beats
    clear_mem(); put_desc(0, 32'h0005_0000, 32'h8000_0010);
    run_case("odd buffer", "R9", 32'h0000_5800, 7, 1'b1, 1'b0);

    // R9: zero-length buffer, no fetch
    clear_mem(); put_desc(0, 32'h0006_0000, 32'h8000_0010);
    run_case("empty buffer", "R9", 32'h0000_6000, 0, 1'b0, 1'b0);

    // R5: no final flag, page limit stops the walk at 512 descriptors
    clear_mem();
    for (int i = 0; i < 600; i++) put_desc(i, 32'h0100_0000 + 32'(i*16), 32'h0000_0002);
    run_case("page limit", "R5", 32'h0000_8000, 5000, 1'b1, 1'b0);

    rnd_on = 1'b1;
    // R10: start while busy is ignored; second run reloads from base
    clear_mem();
    put_desc(0, 32'h0007_0000, 32'h0000_0040); put_desc(1, 32'h0008_0000, 32'h8000_0080);
    run_case("restart ignored", "R9", 32'h0000_7000, 150, 1'b0, 1'b1);
    run_case("rerun", "R4", 32'h0000_7000, 400, 1'b1, 1'b0);

    // random tables, buffers, directions and handshakes
    for (int t = 0; t < 8; t++) begin
      int nd = 2 + int'($urandom % 5);
      clear_mem();
      for (int i = 0; i < nd; i++) begin
        logic [31:0] cw = 32'($urandom % 400);
        if (i == nd - 1) cw[31] = 1'b1;
        if (cw[15:1] == 15'd0) cw[15:0] = 16'd6;
        put_desc(i, $urandom & 32'hFFFF_FFFC, cw);
      end
      run_case($sformatf("random %0d", t), "R4", 32'h0000_9000 + 32'(t*256),
               1 + int'($urandom % 1500), 1'($urandom % 2), 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule